// File: doc/BRIEF.md
# Little-Endian Load/Store Memory Stage

This block is the data-memory access stage of a 32-bit pipelined processor whose instruction and data memories are separate. Each cycle it may accept one request made of a byte address, store data and a decoded access kind. The five kinds are word load, signed byte load, unsigned byte load, word store and byte store. It splits the byte address into a RAM word index and a lane number. It drives a synchronous word-wide data RAM with one write enable per byte lane. One cycle later it returns the load result, sign- or zero-extended as the access kind demands.

Only a window of the low address space is backed by RAM. With the default parameters this window is the lowest 1 MB, byte addresses 0x00000000 to 0x000FFFFF. The stage never lets a request outside the window reach the RAM. Stores there are dropped and loads there return zero, so a high address can never alias a low location. Byte lanes are little-endian. Word accesses are assumed aligned.

Top module: `lsu_mem_stage`

## Requirements
- R1: Access kind codes on `req_op` are 0 word load, 1 signed byte load, 2 unsigned byte load, 3 word store and 4 byte store. A word load returns the whole 32-bit word held at the addressed word.
- R2: Lanes are little-endian. Byte offset k (address bits 1:0) selects data bits 8k+7:8k of the RAM word, both for byte loads and for byte-store enables.
- R3: A signed byte load copies bit 7 of the selected byte into result bits 31:8.
- R4: An unsigned byte load returns the selected byte in bits 7:0 with bits 31:8 zero.
- R5: A backed byte store asserts exactly one of the four bits of `mem_we`, namely bit k for byte offset k. It drives bits 7:0 of `req_wdata` onto all four lanes of `mem_wdata`.
- R6: A backed word store asserts all four bits of `mem_we` and passes `req_wdata` unchanged. Address bits 1:0 are ignored for word loads and word stores.
- R7: An address below 2^WIN_LOG2 is backed. For it, `mem_en` is high and `mem_idx` carries address bits WIN_LOG2-1:2.
- R8: For a request at or above 2^WIN_LOG2, `mem_en` is low and `mem_we` is zero, so RAM contents are left unchanged and no low location is aliased.
- R9: A load from an unbacked address returns zero.
- R10: A load presented in cycle t raises `rsp_valid` and its result on `rsp_data` in cycle t+1. A store, an idle cycle or an unused code yields `rsp_valid` low in the next cycle.
- R11: While reset is asserted and after it, `rsp_valid` is low until a load arrives. Codes 5 to 7 leave `mem_en` low and `mem_we` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Access kind code |
| req_addr | input | ADDR_W (32) | Byte address |
| req_wdata | input | DATA_W (32) | Store data |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | DATA_W/8 (4) | Per-lane RAM write enables |
| mem_idx | output | WIN_LOG2-2 (18) | RAM word index |
| mem_wdata | output | DATA_W (32) | RAM write data, lanes steered |
| mem_rdata | input | DATA_W (32) | RAM read data, one cycle after `mem_en` |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | DATA_W (32) | Extended load result |

## Verification
The bench builds the stage with its defaults: 32-bit data and address, and a 1 MB window (WIN_LOG2 = 20). It backs the RAM with a sparse model, so the full window can be addressed while storage is allocated only for the words that are touched. This places the last backed byte at 0x000FFFFF, the first unbacked byte at 0x00100000 and the very top of the address space within direct reach. Random traffic is biased so that it falls both into a small, heavily reused low region and across the window edge. This lets stores above the edge be followed by loads from the low words they would alias if the window wrapped.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [2:0] {
        ACC_LDW  = 3'd0,
        ACC_LDB  = 3'd1,
        ACC_LDBU = 3'd2,
        ACC_STW  = 3'd3,
        ACC_STB  = 3'd4
    } acc_kind_e;

    function automatic logic kind_is_load(input acc_kind_e k);
        return (k == ACC_LDW) || (k == ACC_LDB) || (k == ACC_LDBU);
    endfunction

    function automatic logic kind_is_store(input acc_kind_e k);
        return (k == ACC_STW) || (k == ACC_STB);
    endfunction

endpackage

// File: rtl/lsu_addr_split.sv
module lsu_addr_split #(
    parameter int ADDR_W   = 32,
    parameter int WIN_LOG2 = 20,
    parameter int OFF_W    = 2
) (
    input  logic [ADDR_W-1:0]         addr_i,
    output logic                      backed_o,
    output logic [WIN_LOG2-OFF_W-1:0] widx_o,
    output logic [OFF_W-1:0]          lane_o
);
    assign widx_o = addr_i[WIN_LOG2-1:OFF_W];
    assign lane_o = addr_i[OFF_W-1:0];

    generate
        if (WIN_LOG2 >= ADDR_W) begin : g_whole_space
            assign backed_o = 1'b1;
        end else begin : g_window
            assign backed_o = (addr_i[ADDR_W-1:WIN_LOG2] == '0);
        end
    endgenerate
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2
) (
    input  acc_kind_e               kind_i,
    input  logic [OFF_W-1:0]        lane_i,
    input  logic                    allow_i,
    input  logic [DATA_W-1:0]       data_i,
    output logic [DATA_W/8-1:0]     we_o,
    output logic [DATA_W-1:0]       data_o
);
    localparam int LANES = DATA_W / 8;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign data_o[8*g +: 8] = (kind_i == ACC_STB) ? data_i[7:0] : data_i[8*g +: 8];
            assign we_o[g] = allow_i &
                             ((kind_i == ACC_STW) |
                              ((kind_i == ACC_STB) & (lane_i == OFF_W'(g))));
        end
    endgenerate
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [OFF_W-1:0]  lane_i,
    input  logic              wide_i,
    input  logic              sign_i,
    input  logic              live_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0][7:0] bytes;
    logic [7:0]            pick;

    assign bytes = word_i;

    always_comb begin
        pick = bytes[lane_i];
        if (!live_i) begin
            data_o = '0;
        end else if (wide_i) begin
            data_o = word_i;
        end else begin
            data_o = {{(DATA_W-8){sign_i & pick[7]}}, pick};
        end
    end
endmodule

// File: rtl/lsu_mem_stage.sv
module lsu_mem_stage
    import lsu_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int WIN_LOG2 = 20
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [2:0]                        req_op,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [DATA_W-1:0]                 req_wdata,
    output logic                              mem_en,
    output logic [DATA_W/8-1:0]               mem_we,
    output logic [WIN_LOG2-$clog2(DATA_W/8)-1:0] mem_idx,
    output logic [DATA_W-1:0]                 mem_wdata,
    input  logic [DATA_W-1:0]                 mem_rdata,
    output logic                              rsp_valid,
    output logic [DATA_W-1:0]                 rsp_data
);
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);
    localparam int WIDX_W = WIN_LOG2 - OFF_W;

    typedef struct packed {
        logic             vld;
        logic             wide;
        logic             sign;
        logic             backed;
        logic [OFF_W-1:0] lane;
    } ld_ctl_t;

    acc_kind_e         kind;
    logic              backed;
    logic [WIDX_W-1:0] widx;
    logic [OFF_W-1:0]  lane;
    logic              is_ld;
    logic              is_st;
    ld_ctl_t           ctl_d, ctl_q;

    assign kind = acc_kind_e'(req_op);

    lsu_addr_split #(
        .ADDR_W   (ADDR_W),
        .WIN_LOG2 (WIN_LOG2),
        .OFF_W    (OFF_W)
    ) u_split (
        .addr_i   (req_addr),
        .backed_o (backed),
        .widx_o   (widx),
        .lane_o   (lane)
    );

    lsu_store_lanes #(
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W)
    ) u_store (
        .kind_i  (kind),
        .lane_i  (lane),
        .allow_i (req_valid & is_st & backed),
        .data_i  (req_wdata),
        .we_o    (mem_we),
        .data_o  (mem_wdata)
    );

    always_comb begin
        is_ld   = kind_is_load(kind);
        is_st   = kind_is_store(kind);
        mem_en  = req_valid & backed & (is_ld | is_st);
        mem_idx = widx;

        ctl_d        = '0;
        ctl_d.vld    = req_valid & is_ld;
        ctl_d.wide   = (kind == ACC_LDW);
        ctl_d.sign   = (kind == ACC_LDB);
        ctl_d.backed = backed;
        ctl_d.lane   = lane;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    lsu_load_extend #(
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W)
    ) u_extend (
        .word_i (mem_rdata),
        .lane_i (ctl_q.lane),
        .wide_i (ctl_q.wide),
        .sign_i (ctl_q.sign),
        .live_i (ctl_q.vld & ctl_q.backed),
        .data_o (rsp_data)
    );

    assign rsp_valid = ctl_q.vld;
endmodule

// File: rtl/lsu_mem_stage_chk.sv
module lsu_mem_stage_chk #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int WIN_LOG2 = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [2:0]          req_op,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [DATA_W-1:0]   req_wdata,
    input logic                mem_en,
    input logic [DATA_W/8-1:0] mem_we,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic                rsp_valid,
    input logic [DATA_W-1:0]   rsp_data
);
    localparam int LANES = DATA_W / 8;

    logic in_win;
    logic ld_req;

    assign in_win = ((req_addr >> WIN_LOG2) == '0);
    assign ld_req = req_valid && (req_op <= 3'd2);

    // R5
    byte_store_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd4 && in_win |-> $countones(mem_we) == 1);

    // R5
    byte_store_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd4 && in_win |-> mem_wdata == {LANES{req_wdata[7:0]}});

    // R6
    word_store_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd3 && in_win |-> (&mem_we) && mem_wdata == req_wdata);

    // R8
    outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !in_win |-> mem_we == '0 && !mem_en);

    // R9
    outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req && !in_win |=> rsp_valid && rsp_data == '0);

    // R3
    signed_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd1 |=> rsp_data[DATA_W-1:8] == {(DATA_W-8){rsp_data[7]}});

    // R4
    unsigned_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd2 |=> rsp_data[DATA_W-1:8] == '0);

    // R10
    load_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |=> rsp_valid);

    // R10
    no_spurious_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_req |=> !rsp_valid);

    // R11
    unused_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op > 3'd4 |-> mem_we == '0 && !mem_en);
endmodule

bind lsu_mem_stage lsu_mem_stage_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .WIN_LOG2 (WIN_LOG2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/sim_lsu_mem_stage.sv
`timescale 1ns/1ps
module sim_lsu_mem_stage;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 32;
    localparam int WIN_LOG2 = 20;
    localparam int IDX_W    = WIN_LOG2 - 2;
    localparam longint WIN  = longint'(1) << WIN_LOG2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = 3'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              mem_en;
    logic [3:0]        mem_we;
    logic [IDX_W-1:0]  mem_idx;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    bit [31:0] ram [int];
    bit [7:0]  refm [longint];

    always #2.5 clk = ~clk;

    lsu_mem_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_en(mem_en),
        .mem_we(mem_we), .mem_idx(mem_idx), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            bit [31:0] w;
            w = ram.exists(int'(mem_idx)) ? ram[int'(mem_idx)] : 32'd0;
            mem_rdata <= w;
            for (int i = 0; i < 4; i++) begin
                if (mem_we[i]) w[8*i +: 8] = mem_wdata[8*i +: 8];
            end
            if (mem_we != 4'd0) ram[int'(mem_idx)] = w;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit [7:0] ref_byte(input longint a);
        if (a >= WIN) return 8'h00;
        return refm.exists(a) ? refm[a] : 8'h00;
    endfunction

    function automatic bit [31:0] exp_load(input bit [2:0] op, input bit [31:0] addr);
        longint base;
        bit [7:0] b;
        base = longint'(addr) & ~longint'(3);
        if (op == 3'd0)
            return {ref_byte(base+3), ref_byte(base+2), ref_byte(base+1), ref_byte(base)};
        b = ref_byte(longint'(addr));
        if (op == 3'd1) return {{24{b[7]}}, b};
        return {24'd0, b};
    endfunction

    task automatic ref_store(input bit [2:0] op, input bit [31:0] addr, input bit [31:0] d);
        longint base;
        if (longint'(addr) >= WIN) return;
        base = longint'(addr) & ~longint'(3);
        if (op == 3'd3) begin
            for (int i = 0; i < 4; i++) refm[base+i] = d[8*i +: 8];
        end else if (op == 3'd4) begin
            refm[longint'(addr)] = d[7:0];
        end
    endtask

    task automatic do_op(input bit [2:0] op, input bit [31:0] addr, input bit [31:0] d);
        bit inwin;
        bit [31:0] exp;
        inwin = longint'(addr) < WIN;
        exp = exp_load(op, addr);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = d;
        #1;
        if (op > 3'd4) begin
            chk(!mem_en && mem_we == 4'd0, "R11", {27'd0, mem_en, mem_we}, 32'd0);
        end else if (!inwin) begin
            chk(!mem_en && mem_we == 4'd0, "R8", {27'd0, mem_en, mem_we}, 32'd0);
        end else begin
            chk(mem_en && mem_idx == addr[WIN_LOG2-1:2], "R7", {13'd0, mem_en, mem_idx},
                {13'd0, 1'b1, addr[WIN_LOG2-1:2]});
            if (op == 3'd4)
                chk(mem_we == (4'd1 << addr[1:0]) && mem_wdata == {4{d[7:0]}}, "R5 R2",
                    {mem_we, mem_wdata[27:0]}, {4'd1 << addr[1:0], {4{d[7:0]}}[27:0]});
            else if (op == 3'd3)
                chk(mem_we == 4'hF && mem_wdata == d, "R6", mem_wdata, d);
            else
                chk(mem_we == 4'd0, "R1", {28'd0, mem_we}, 32'd0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (op <= 3'd2) begin
            chk(rsp_valid && rsp_data == exp,
                !inwin ? "R9" : (op == 3'd0 ? "R1 R6" : (op == 3'd1 ? "R3 R2" : "R4 R2")),
                rsp_data, exp);
        end else begin
            chk(!rsp_valid, "R10", {31'd0, rsp_valid}, 32'd0);
        end
        ref_store(op, addr, d);
    endtask

    function automatic bit [31:0] pick_addr();
        int r;
        r = $urandom_range(0, 99);
        if (r < 60) return $urandom_range(0, 255);
        if (r < 75) return 32'h000FFF00 + $urandom_range(0, 255);
        if (r < 90) return 32'h00100000 + $urandom_range(0, 255);
        if (r < 95) return $urandom_range(0, 255) | 32'h00100000 << $urandom_range(0, 11);
        return $urandom();
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!rsp_valid, "R11", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid && !mem_en, "R11", {30'd0, rsp_valid, mem_en}, 32'd0);

        // directed corners
        do_op(3'd3, 32'h00000100, 32'h8BADF00D);   // R6
        do_op(3'd0, 32'h00000100, 32'd0);          // R1
        for (int k = 0; k < 4; k++) begin
            do_op(3'd1, 32'h00000100 + k, 32'd0);  // R3 R2
            do_op(3'd2, 32'h00000100 + k, 32'd0);  // R4 R2
        end
        do_op(3'd3, 32'h00000106, 32'hCAFE0780);   // R6 low bits ignored
        do_op(3'd0, 32'h00000107, 32'd0);          // R6
        do_op(3'd4, 32'h000FFFFF, 32'h123456A5);   // R5 last backed byte
        do_op(3'd1, 32'h000FFFFF, 32'd0);          // R3
        do_op(3'd3, 32'h00000000, 32'h11223344);
        do_op(3'd3, 32'h00100000, 32'hDEADBEEF);   // R8 must not alias
        do_op(3'd4, 32'h00100001, 32'h000000EE);   // R8
        do_op(3'd0, 32'h00000000, 32'd0);          // R8 low word intact
        do_op(3'd0, 32'h00100000, 32'd0);          // R9
        do_op(3'd1, 32'hFFFFFFFF, 32'd0);          // R9
        do_op(3'd5, 32'h00000000, 32'hFFFFFFFF);   // R11
        do_op(3'd7, 32'h00000004, 32'hFFFFFFFF);   // R11
        do_op(3'd0, 32'h00000000, 32'd0);          // R11 nothing written

        // random mix
        for (int n = 0; n < 3000; n++) begin
            bit [2:0] op;
            op = ($urandom_range(0, 19) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
            do_op(op, pick_addr(), $urandom());
        end

        // sweep back every low word touched, R8 aliasing would surface here
        for (int a = 0; a < 256; a += 4) do_op(3'd0, 32'(a), 32'd0);
        for (int a = 32'h000FFF00; a < 32'h00100000; a += 4) do_op(3'd0, 32'(a), 32'd0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule